// File: doc/BRIEF.md
# Systolic Matrix Multiply Array

This block multiplies two square matrices, C = A×B, on a grid of DIM×DIM multiply-accumulate cells. The default is DIM = 3. Each cell owns one result element c[i][j], and that partial sum never leaves its cell. Operands of A travel from cell to cell along a row, and operands of B travel down a column. Every link between neighbours is a register, and no signal is broadcast across the grid.

The caller presents one beat per k step with in_valid high. A beat carries column k of A on a_col and row k of B on b_row. in_first marks the k = 0 beat and in_last marks the k = DIM−1 beat. Inside the block, lane i of each input is delayed by i cycles. This skew makes a[i][k] and b[k][j] reach cell (i,j) in the same cycle. Cycles with in_valid low may appear between beats and are ignored.

When the last product has been added in the far corner cell, done rises. All DIM² results are then final on c_flat and stay there until the next stream begins. A new stream should start only after done is high.

Top module: `sys_matmul_array`

## Requirements
- R1: While rst is high at a rising edge, every element of c_flat becomes 0 and done becomes 0.
- R2: Beat k (0-based) carries a[i][k] in a_col bits [i·8 +: 8] and b[k][j] in b_row bits [j·8 +: 8]. After done, element c[i][j] = Σk a[i][k]·b[k][j] (unsigned) appears in c_flat bits [(i·DIM+j)·18 +: 18].
- R3: A beat with in_first high restarts the sum in each cell. No value from an earlier stream enters the new results.
- R4: Beats are counted from the rising edge that samples the first beat, which is edge 1. With DIM back-to-back beats, done reads 0 after edges 1 to 3·DIM−3 and reads 1 after edge 3·DIM−2.
- R5: Cycles with in_valid low change no result, whatever a_col, b_row, in_first and in_last hold. done rises 2·(DIM−1) edges after the edge that samples the in_last beat.
- R6: Once done is high and in_valid stays low, done stays high and c_flat is unchanged. done reads 0 after the edge that samples a beat with in_valid and in_first high.
- R7: With every operand equal to 255, each result is DIM·65025 (195075 for DIM = 3) and does not wrap. The result width is 16 + clog2(DIM) bits.
- R8: Each cell receives its A operand and its B operand in the same cycle. Both arrive over registered links from the neighbouring cell or from the input skew.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Current beat carries operands |
| in_first | input | 1 | Beat is k = 0 of a stream |
| in_last | input | 1 | Beat is k = DIM−1 of a stream |
| a_col | input | DIM·8 | Column k of A, lane i = row i |
| b_row | input | DIM·8 | Row k of B, lane j = column j |
| c_flat | output | DIM·DIM·18 | Result elements, row-major |
| done | output | 1 | All results final |

## Verification
Suppose a skew stage or a neighbour link is off by one register. Then a cell pairs a[i][k] with b[k±1][j], and only the results of the cells on that path come out wrong. Those results can be read on c_flat as soon as done rises. A sum that is not cleared by the first-beat tag shows up only on the second stream, as the first stream's value added to the correct one. A misplaced done flag shows at the port as a rise one or more edges away from 3·DIM−2. The operand-alignment and hold properties flag a bad state in the cycle it appears, before the results are read.

// File: rtl/mm_pkg.sv
package mm_pkg;

    parameter int unsigned MM_DW = 8;

    typedef logic [MM_DW-1:0] opnd_t;

    // Row operand token: carries the stream tags along the row.
    typedef struct packed {
        logic  vld;
        logic  first;
        logic  last;
        opnd_t val;
    } a_tok_t;

    // Column operand token.
    typedef struct packed {
        logic  vld;
        opnd_t val;
    } b_tok_t;

    // Accumulator width: one full product plus headroom for dim additions.
    function automatic int unsigned acc_width(input int unsigned dim);
        return 2 * MM_DW + ((dim > 1) ? $clog2(dim) : 0);
    endfunction

endpackage

// File: rtl/mm_skew.sv
module mm_skew #(
    parameter int unsigned LANES = 3,
    parameter type         T     = logic
) (
    input  logic clk,
    input  logic rst,
    input  T     din  [LANES],
    output T     dout [LANES]
);

    // Lane l is delayed by l register stages.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l == 0) begin : g_pass
            assign dout[l] = din[l];
        end else begin : g_dly
            T stg [l];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int s = 0; s < l; s++) stg[s] <= '0;
                end else begin
                    stg[0] <= din[l];
                    for (int s = 1; s < l; s++) stg[s] <= stg[s-1];
                end
            end
            assign dout[l] = stg[l-1];
        end
    end

    if (LANES > 1) begin : g_chk
        // R4: lane 1 trails its input by exactly one edge
        p_skew_one_r4: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> dout[1] == $past(din[1]));
    end

endmodule

// File: rtl/mm_pe.sv
module mm_pe
    import mm_pkg::*;
#(
    parameter int unsigned AW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  a_tok_t        a_i,
    input  b_tok_t        b_i,
    output a_tok_t        a_o,
    output b_tok_t        b_o,
    output logic [AW-1:0] acc_o,
    output logic          fin_o
);

    logic [2*MM_DW-1:0] prod;
    logic [AW-1:0]      base;
    logic [AW-1:0]      acc_q;

    assign prod  = a_i.val * b_i.val;
    assign base  = a_i.first ? '0 : acc_q;
    assign fin_o = a_i.vld & a_i.last;
    assign acc_o = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_o   <= '0;
            b_o   <= '0;
            acc_q <= '0;
        end else begin
            a_o <= a_i;
            b_o <= b_i;
            if (a_i.vld) acc_q <= base + AW'(prod);
        end
    end

    // R8: both operand streams reach this cell in the same cycle
    p_lane_align_r8: assert property (@(posedge clk) disable iff (rst)
        a_i.vld == b_i.vld);

    // R5: no operand, no change to the partial sum
    p_acc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !a_i.vld |=> $stable(acc_o));

    // R3: a first-tagged operand leaves only its own product
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (a_i.vld && a_i.first) |=> acc_o == $past(a_i.val) * $past(b_i.val));

endmodule

// File: rtl/sys_matmul_array.sv
module sys_matmul_array
    import mm_pkg::*;
#(
    parameter  int unsigned DIM = 3,
    localparam int unsigned DW  = MM_DW,
    localparam int unsigned AW  = acc_width(DIM)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  in_first,
    input  logic                  in_last,
    input  logic [DIM*DW-1:0]     a_col,
    input  logic [DIM*DW-1:0]     b_row,
    output logic [DIM*DIM*AW-1:0] c_flat,
    output logic                  done
);

    a_tok_t a_src [DIM];
    a_tok_t a_skw [DIM];
    b_tok_t b_src [DIM];
    b_tok_t b_skw [DIM];

    a_tok_t a_h [DIM][DIM+1];
    b_tok_t b_v [DIM+1][DIM];
    logic   fin [DIM*DIM];

    for (genvar n = 0; n < DIM; n++) begin : g_src
        assign a_src[n] = '{vld: in_valid, first: in_first, last: in_last,
                            val: a_col[n*DW +: DW]};
        assign b_src[n] = '{vld: in_valid, val: b_row[n*DW +: DW]};
        assign a_h[n][0] = a_skw[n];
        assign b_v[0][n] = b_skw[n];
    end

    mm_skew #(.LANES(DIM), .T(a_tok_t)) u_skew_a (
        .clk (clk), .rst (rst), .din (a_src), .dout (a_skw)
    );

    mm_skew #(.LANES(DIM), .T(b_tok_t)) u_skew_b (
        .clk (clk), .rst (rst), .din (b_src), .dout (b_skw)
    );

    for (genvar r = 0; r < DIM; r++) begin : g_row
        for (genvar c = 0; c < DIM; c++) begin : g_col
            mm_pe #(.AW(AW)) u_pe (
                .clk   (clk),
                .rst   (rst),
                .a_i   (a_h[r][c]),
                .b_i   (b_v[r][c]),
                .a_o   (a_h[r][c+1]),
                .b_o   (b_v[r+1][c]),
                .acc_o (c_flat[(r*DIM+c)*AW +: AW]),
                .fin_o (fin[r*DIM+c])
            );
        end
    end

    logic start_beat;
    assign start_beat = in_valid & in_first;

    always_ff @(posedge clk) begin
        if (rst)                     done <= 1'b0;
        else if (fin[DIM*DIM-1])     done <= 1'b1;
        else if (start_beat)         done <= 1'b0;
    end

    // R6: done is sticky until a new stream starts
    p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !start_beat) |=> done);

    // R6: results are frozen while done and idle
    p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !in_valid) |=> $stable(c_flat));

endmodule

// File: tb/sys_matmul_array_tb_top.sv
`timescale 1ns/1ps
module sys_matmul_array_tb_top;

    localparam int DIM = 3;
    localparam int DW  = 8;
    localparam int AW  = 18;
    localparam int NT  = 4;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  in_valid, in_first, in_last;
    logic [DIM*DW-1:0]     a_col, b_row;
    logic [DIM*DIM*AW-1:0] c_flat;
    logic                  done;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sys_matmul_array #(.DIM(DIM)) dut_i (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_first (in_first),
        .in_last (in_last), .a_col (a_col), .b_row (b_row),
        .c_flat (c_flat), .done (done)
    );

    // Matrices: element (r,c) at bits [(r*3+c)*8 +: 8].
    localparam logic [71:0] TAB_A [NT] = '{
        72'h01_00_00_00_01_00_00_00_01,
        72'h09_08_07_06_05_04_03_02_01,
        72'hFF_FF_FF_FF_FF_FF_FF_FF_FF,
        72'h10_20_30_40_50_60_70_80_90
    };
    localparam logic [71:0] TAB_B [NT] = '{
        72'h09_08_07_06_05_04_03_02_01,
        72'h02_05_03_07_01_04_06_00_08,
        72'hFF_FF_FF_FF_FF_FF_FF_FF_FF,
        72'h00_00_FF_00_FF_00_FF_00_00
    };
    localparam int TAB_GAP [NT] = '{0, 2, 0, 1};
    string tags [NT] = '{"R8", "R5", "R7", "R3"};

    function automatic int expect_c(input logic [71:0] a, input logic [71:0] b,
                                    input int i, input int j);
        int s = 0;
        for (int k = 0; k < DIM; k++)
            s += int'(a[(i*DIM+k)*DW +: DW]) * int'(b[(k*DIM+j)*DW +: DW]);
        return s;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_results(input string req, input logic [71:0] a,
                                 input logic [71:0] b);
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++)
                chk(req, int'(c_flat[(i*DIM+j)*AW +: AW]), expect_c(a, b, i, j));
    endtask

    task automatic idle_inputs();
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        a_col = '0; b_row = '0;
    endtask

    // Called at a negedge. Returns the edge count at which done was seen.
    task automatic run_case(input logic [71:0] a, input logic [71:0] b,
                            input int gap, output int done_edge);
        int e = 0;
        for (int k = 0; k < DIM; k++) begin
            in_valid = 1'b1;
            in_first = (k == 0);
            in_last  = (k == DIM-1);
            for (int n = 0; n < DIM; n++) begin
                a_col[n*DW +: DW] = a[(n*DIM+k)*DW +: DW];
                b_row[n*DW +: DW] = b[(k*DIM+n)*DW +: DW];
            end
            @(posedge clk); e++; @(negedge clk);
            if (e == 1) chk("R6 done low after first beat", int'(done), 0);
            if (k < DIM-1) begin
                for (int g = 0; g < gap; g++) begin
                    in_valid = 1'b0; in_first = 1'b1; in_last = 1'b1;
                    a_col = {DIM{8'hAA}}; b_row = {DIM{8'h55}};
                    @(posedge clk); e++; @(negedge clk);
                end
            end
        end
        idle_inputs();
        while (!done && e < 60) begin
            @(posedge clk); e++; @(negedge clk);
        end
        done_edge = e;
    endtask

    initial begin
        #(200000 * 8);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int de;
        int exp_edge;
        logic [DIM*DIM*AW-1:0] snap;
        rst = 1'b1;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        for (int n = 0; n < DIM*DIM; n++)
            chk("R1 result cleared", int'(c_flat[n*AW +: AW]), 0);
        chk("R1 done cleared", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int t = 0; t < NT; t++) begin
            run_case(TAB_A[t], TAB_B[t], TAB_GAP[t], de);
            exp_edge = DIM + (DIM-1)*TAB_GAP[t] + 2*(DIM-1);
            if (TAB_GAP[t] == 0) chk("R4 done latency", de, exp_edge);
            else                 chk("R5 done after last beat", de, exp_edge);
            check_results("R2", TAB_A[t], TAB_B[t]);
            check_results(tags[t], TAB_A[t], TAB_B[t]);
            snap = c_flat;
            repeat (4) begin @(posedge clk); @(negedge clk); end
            chk("R6 done held", int'(done), 1);
            chk("R6 results held", int'(c_flat == snap), 1);
        end

        // R7: explicit full-scale value
        run_case(TAB_A[2], TAB_B[2], 0, de);
        chk("R7 full scale", int'(c_flat[0 +: AW]), 3 * 65025);
        chk("R7 full scale corner", int'(c_flat[(DIM*DIM-1)*AW +: AW]), 195075);

        // R1: reset mid-result clears everything
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 corner after reset", int'(c_flat[(DIM*DIM-1)*AW +: AW]), 0);
        rst = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule